// File: doc/BRIEF.md
# Video Payload Framer with Header and Trailer Insertion

This block turns a byte stream of video into the payload packets of an isochronous video endpoint. Each frame on the input is marked by a start flag on its first byte and an end flag on its last byte. At the start of every frame the block sends a programmable run of header bytes. It then passes the video bytes through and appends a programmable run of trailer bytes. The block cuts the combined byte stream into packets of at most `MAX_PKT` bytes and closes the frame with one to four zero-length packets, which the host uses to find frame boundaries.

A microcontroller-side register port writes eight header byte registers at addresses 0 to 7, four trailer byte registers at addresses 8 to 11, and a control register at address 12. The control register holds the header byte count in bits [3:0], the trailer byte count in bits [6:4] and the zero-length packet selector in bits [8:7]. A count above its maximum is treated as the maximum. The block takes a fresh snapshot of the control register for each frame.

Both streams use valid/ready handshakes, and a beat moves only on a cycle where valid and ready are both high. Once the output raises `out_valid`, it keeps the beat unchanged until `out_ready` accepts it. While video bytes pass through, `in_ready` follows `out_ready` within the same cycle and `out_valid` follows `in_valid`. During header, trailer and zero-length packet beats, and while a start-of-frame byte waits in the idle state, `in_ready` stays low. The source must hold a byte and its flags stable until it is accepted. There is no storage at either edge.

Top module: `vid_framer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 0 while `in_valid` is 0.
- R2: Before the video of a frame, the block emits H header bytes, where H = min(ctl[3:0], 8). Header byte k is the value of header register k (address k).
- R3: After the last video byte of a frame (the byte with `in_eof`=1), the block emits T trailer bytes, where T = min(ctl[6:4], 4). Trailer byte k is the value of trailer register k (address 8+k).
- R4: Video bytes come out unchanged and in order, between the header and the trailer.
- R5: H, T and the zero-length packet count are sampled when a start-of-frame byte appears in the idle state. A control write made during a frame affects only later frames.
- R6: Header, video and trailer bytes share packets. `out_last`=1 marks every MAX_PKT-th byte of a packet, and it also marks the final payload byte of a frame.
- R7: After the final payload byte, the block emits Z = ctl[8:7]+1 zero-length packets. Each is a single beat with `out_zlp`=1, `out_last`=1 and `out_data`=0, and no beat follows them until the next frame starts.
- R8: While `out_valid`=1 and `out_ready`=0, the output beat (`out_data`, `out_last`, `out_zlp`) is held unchanged on the next cycle.
- R9: A byte offered while idle without `in_sof` is accepted (`in_ready`=1) and discarded with no output. A start-of-frame byte is never accepted in the idle state itself.
- R10: With H = T = 0, the output is exactly the video bytes, still cut into packets and still followed by the zero-length packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0-7 header, 8-11 trailer, 12 control |
| reg_wdata | input | 9 | Write data (header and trailer registers use bits [7:0]) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted this cycle when high with `in_valid` |
| in_data | input | 8 | Input video byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Output payload byte (0 on zero-length beats) |
| out_last | output | 1 | Last beat of the current packet |
| out_zlp | output | 1 | Beat is a zero-length packet |

## Verification
Video bytes reach the output in the same cycle they are offered. Header, trailer and zero-length beats come from registered state, so each appears one cycle after the handshake that moved the sequence on. The first header beat appears one cycle after the start-of-frame byte is seen in the idle state. The bench builds the full expected beat list for a frame from its own copy of the registers before driving the first byte. On every falling edge it compares whatever beat is valid against the head of that list, and it removes the head only when `out_ready` is high, so every stall and every gap is checked. Inputs change one time unit after the rising edge and are sampled half a period later, so a handshake seen at a falling edge is exactly the one that completes at the next rising edge.

// File: rtl/vfr_pkg.sv
package vfr_pkg;
  localparam int BYTE_W = 8;
  localparam int HDR_N  = 8;
  localparam int TRL_N  = 4;
  localparam int CTL_W  = 9;
  localparam int ADDR_W = 4;
  localparam int HC_W   = $clog2(HDR_N + 1);
  localparam int TC_W   = $clog2(TRL_N + 1);
  localparam int ZC_W   = 3;
  localparam logic [ADDR_W-1:0] ADDR_TRL0 = ADDR_W'(HDR_N);
  localparam logic [ADDR_W-1:0] ADDR_CTL  = ADDR_W'(HDR_N + TRL_N);

  typedef enum logic [2:0] {ST_IDLE, ST_HDR, ST_DATA, ST_TRL, ST_ZLP} vfr_state_e;

  typedef struct packed {
    logic [HC_W-1:0] hcnt;
    logic [TC_W-1:0] tcnt;
    logic [ZC_W-1:0] zcnt;
  } vfr_cfg_t;
endpackage

// File: rtl/vfr_regs.sv
module vfr_regs
  import vfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTL_W-1:0]  wdata,
  input  logic [HC_W-1:0]   idx,
  output logic [BYTE_W-1:0] hbyte,
  output logic [BYTE_W-1:0] tbyte,
  output vfr_cfg_t          cfg
);
  logic [BYTE_W-1:0] hdr_q [HDR_N];
  logic [BYTE_W-1:0] trl_q [TRL_N];
  logic [CTL_W-1:0]  ctl_q;

  for (genvar g = 0; g < HDR_N; g++) begin : g_hdr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              hdr_q[g] <= '0;
      else if (we && addr == ADDR_W'(g))       hdr_q[g] <= wdata[BYTE_W-1:0];
    end
  end

  for (genvar g = 0; g < TRL_N; g++) begin : g_trl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   trl_q[g] <= '0;
      else if (we && addr == ADDR_TRL0 + ADDR_W'(g)) trl_q[g] <= wdata[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ctl_q <= '0;
    else if (we && addr == ADDR_CTL) ctl_q <= wdata;
  end

  always_comb begin
    hbyte = '0;
    for (int k = 0; k < HDR_N; k++)
      if (idx == HC_W'(k)) hbyte = hdr_q[k];
    tbyte = '0;
    for (int k = 0; k < TRL_N; k++)
      if (idx == HC_W'(k)) tbyte = trl_q[k];
  end

  // saturating decode of the count fields
  always_comb begin
    cfg.hcnt = (ctl_q[3:0] > 4'(HDR_N)) ? HC_W'(HDR_N) : HC_W'(ctl_q[3:0]);
    cfg.tcnt = (ctl_q[6:4] > 3'(TRL_N)) ? TC_W'(TRL_N) : TC_W'(ctl_q[6:4]);
    cfg.zcnt = ZC_W'(ctl_q[8:7]) + ZC_W'(1);
  end
endmodule

// File: rtl/vfr_pktcnt.sv
module vfr_pktcnt #(
  parameter int MAX_PKT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic closed,
  output logic at_cut
);
  localparam int CW = $clog2(MAX_PKT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (beat && closed)  cnt_q <= '0;
    else if (beat)            cnt_q <= cnt_q + CW'(1);
  end

  assign at_cut = (cnt_q == CW'(MAX_PKT - 1));
endmodule

// File: rtl/vfr_ctrl.sv
module vfr_ctrl
  import vfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  vfr_cfg_t          cfg,
  input  logic [BYTE_W-1:0] hbyte,
  input  logic [BYTE_W-1:0] tbyte,
  output logic [HC_W-1:0]   idx,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_zlp,
  input  logic              out_ready,
  input  logic              at_cut,
  output logic              beat
);
  vfr_state_e      state_q;
  logic [HC_W-1:0] idx_q, hcnt_q;
  logic [TC_W-1:0] tcnt_q;
  logic [ZC_W-1:0] zleft_q;
  logic            payload, final_byte, fire, hdr_end, trl_end;

  assign idx     = idx_q;
  assign hdr_end = (idx_q == hcnt_q - HC_W'(1));
  assign trl_end = (idx_q == HC_W'(tcnt_q) - HC_W'(1));

  always_comb begin
    in_ready   = 1'b0;
    out_valid  = 1'b0;
    out_data   = '0;
    out_zlp    = 1'b0;
    payload    = 1'b0;
    final_byte = 1'b0;
    case (state_q)
      ST_IDLE: in_ready = in_valid && !in_sof;
      ST_HDR: begin
        out_valid = 1'b1;
        out_data  = hbyte;
        payload   = 1'b1;
      end
      ST_DATA: begin
        out_valid  = in_valid;
        out_data   = in_data;
        in_ready   = out_ready;
        payload    = 1'b1;
        final_byte = in_eof && (tcnt_q == '0);
      end
      ST_TRL: begin
        out_valid  = 1'b1;
        out_data   = tbyte;
        payload    = 1'b1;
        final_byte = trl_end;
      end
      ST_ZLP: begin
        out_valid = 1'b1;
        out_zlp   = 1'b1;
      end
      default: ;
    endcase
    out_last = out_zlp || (payload && (at_cut || final_byte));
    fire     = out_valid && out_ready;
    beat     = fire && payload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      hcnt_q  <= '0;
      tcnt_q  <= '0;
      zleft_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid && in_sof) begin
          hcnt_q  <= cfg.hcnt;
          tcnt_q  <= cfg.tcnt;
          zleft_q <= cfg.zcnt;
          idx_q   <= '0;
          state_q <= (cfg.hcnt != '0) ? ST_HDR : ST_DATA;
        end
        ST_HDR: if (fire) begin
          if (hdr_end) begin
            idx_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            idx_q <= idx_q + HC_W'(1);
          end
        end
        ST_DATA: if (fire && in_eof) begin
          idx_q   <= '0;
          state_q <= (tcnt_q != '0) ? ST_TRL : ST_ZLP;
        end
        ST_TRL: if (fire) begin
          if (trl_end) state_q <= ST_ZLP;
          else         idx_q   <= idx_q + HC_W'(1);
        end
        ST_ZLP: if (fire) begin
          if (zleft_q == ZC_W'(1)) state_q <= ST_IDLE;
          else                     zleft_q <= zleft_q - ZC_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vid_framer.sv
module vid_framer
  import vfr_pkg::*;
#(
  parameter int MAX_PKT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTL_W-1:0]  reg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_zlp
);
  vfr_cfg_t          cfg;
  logic [BYTE_W-1:0] hbyte, tbyte;
  logic [HC_W-1:0]   idx;
  logic              at_cut, beat;

  vfr_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .idx   (idx),
    .hbyte (hbyte),
    .tbyte (tbyte),
    .cfg   (cfg)
  );

  vfr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .hbyte     (hbyte),
    .tbyte     (tbyte),
    .idx       (idx),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_zlp   (out_zlp),
    .out_ready (out_ready),
    .at_cut    (at_cut),
    .beat      (beat)
  );

  vfr_pktcnt #(.MAX_PKT(MAX_PKT)) u_pkt (
    .clk    (clk),
    .rst_n  (rst_n),
    .beat   (beat),
    .closed (out_last),
    .at_cut (at_cut)
  );
endmodule

// File: rtl/vfr_chk.sv
module vfr_chk #(
  parameter int MAX_PKT = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sof,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_last,
  input logic       out_zlp,
  input logic [7:0] out_data
);
  int   run_q;
  logic prev_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 0;
      prev_last_q <= 1'b1;
    end else if (out_valid && out_ready) begin
      prev_last_q <= out_last;
      run_q       <= out_last ? 0 : run_q + 1;
    end
  end

  AST_CUT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zlp && run_q == MAX_PKT - 1) |-> out_last); // R6
  AST_ZLP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zlp) |-> (out_last && out_data == 8'h00)); // R7
  AST_ZLP_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zlp) |-> prev_last_q); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_zlp))); // R8
  AST_SOF_NOT_TAKEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && !out_valid) |-> !in_ready); // R9
endmodule

bind vid_framer vfr_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sof    (in_sof),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_zlp   (out_zlp),
  .out_data  (out_data)
);

// File: tb/sim_vid_framer.sv
`timescale 1ns/1ps
module sim_vid_framer;
  localparam int MAXP = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [8:0] reg_wdata = '0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid, out_last, out_zlp;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  int         checks = 0, bad = 0;
  bit         stall = 1'b0, done = 1'b0, hold_pend = 1'b0;
  logic [7:0] lfsr = 8'h5b;
  logic [9:0] hold_v;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] hdr_m[8];
  logic [7:0] trl_m[4];
  logic [8:0] ctl_m = '0;

  always #5 clk = ~clk;

  vid_framer #(.MAX_PKT(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_zlp(out_zlp)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall ? lfsr[0] : 1'b1;
  end

  // per-cycle comparison against the reference beat list
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(out_valid && {out_zlp, out_last, out_data} == hold_v, "R8 stalled beat held",
            int'({out_zlp, out_last, out_data}), int'(hold_v));
        hold_pend = 1'b0;
      end
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 beat with no frame in progress", int'({out_zlp, out_last, out_data}), 0);
        end else begin
          chk({out_zlp, out_last, out_data} == exp_q[0], tag_q[0],
              int'({out_zlp, out_last, out_data}), int'(exp_q[0]));
          if (out_ready) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
          end else begin
            hold_pend = 1'b1;
            hold_v    = {out_zlp, out_last, out_data};
          end
        end
      end
    end
  end

  task automatic wr(int a, logic [8:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    if (a < 8)       hdr_m[a]     = d[7:0];
    else if (a < 12) trl_m[a - 8] = d[7:0];
    else if (a == 12) ctl_m       = d;
  endtask

  task automatic send_frame(int n, int seed, int mid_at, logic [8:0] mid_val);
    int         hc, tc, zc;
    logic [7:0] pay[$];
    string      ptag[$];
    hc = (ctl_m[3:0] > 4'd8) ? 8 : int'(ctl_m[3:0]);
    tc = (ctl_m[6:4] > 3'd4) ? 4 : int'(ctl_m[6:4]);
    zc = int'(ctl_m[8:7]) + 1;
    for (int k = 0; k < hc; k++) begin pay.push_back(hdr_m[k]); ptag.push_back("R2 header"); end
    for (int i = 0; i < n; i++) begin
      pay.push_back(8'(seed + 7 * i));
      ptag.push_back((hc == 0 && tc == 0) ? "R10 passthrough" : "R4 video");
    end
    for (int k = 0; k < tc; k++) begin pay.push_back(trl_m[k]); ptag.push_back("R3 trailer"); end
    for (int i = 0; i < pay.size(); i++) begin
      bit lst;
      lst = ((i + 1) % MAXP == 0) || (i == pay.size() - 1);
      exp_q.push_back({1'b0, lst, pay[i]});
      tag_q.push_back(lst ? {ptag[i], " R6 packet end"} : ptag[i]);
    end
    for (int z = 0; z < zc; z++) begin
      exp_q.push_back({1'b1, 1'b1, 8'h00});
      tag_q.push_back("R7 zero-length packet");
    end
    @(posedge clk); #1;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(seed + 7 * i);
      in_sof   = (i == 0);
      in_eof   = (i == n - 1);
      if (i == mid_at) begin
        reg_we = 1'b1; reg_addr = 4'd12; reg_wdata = mid_val;
      end
      @(negedge clk);
      while (!in_ready) begin
        @(posedge clk); #1; reg_we = 1'b0;
        @(negedge clk);
      end
      @(posedge clk); #1;
      reg_we = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    end
    if (mid_at >= 0) ctl_m = mid_val;  // R5: takes effect from the next frame
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R7 no beat after zero-length packets", int'(out_valid), 0);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) hdr_m[k] = '0;
    for (int k = 0; k < 4; k++) trl_m[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    chk(!in_ready, "R1 in_ready after reset", int'(in_ready), 0);

    for (int k = 0; k < 8; k++) wr(k, 9'(8'hA0 + k));
    for (int k = 0; k < 4; k++) wr(8 + k, 9'(8'hC0 + k));

    wr(12, {2'd0, 3'd2, 4'd3});          // H=3 T=2 Z=1
    send_frame(5, 1, -1, '0);

    stall = 1'b1;
    wr(12, {2'd3, 3'd4, 4'd8});          // H=8 T=4 Z=4, crosses packet edges
    send_frame(10, 40, -1, '0);

    wr(12, 9'h07F);                       // saturates to H=8 T=4 (R2, R3)
    send_frame(3, 90, -1, '0);

    stall = 1'b0;
    wr(12, {2'd1, 3'd0, 4'd0});          // R10 passthrough, Z=2
    send_frame(8, 17, -1, '0);
    send_frame(9, 130, -1, '0);

    // R9: stray bytes while idle are swallowed
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_sof = 1'b0; in_data = 8'h77;
      @(negedge clk);
      chk(in_ready, "R9 stray byte accepted", int'(in_ready), 1);
      chk(!out_valid, "R9 stray byte not forwarded", int'(out_valid), 0);
      @(posedge clk); #1;
      in_valid = 1'b0;
    end

    // R5: control write during a frame only affects the following frame
    wr(12, {2'd0, 3'd1, 4'd2});
    send_frame(6, 7, 3, {2'd2, 3'd3, 4'd5});
    send_frame(4, 60, -1, '0);

    stall = 1'b1;
    wr(12, {2'd1, 3'd0, 4'd0});
    send_frame(1, 200, -1, '0);           // single-byte frame, R10
    stall = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule